// File: doc/BRIEF.md
# Chip-Select Wait-State Controller

This block guards one memory region on a processor bus. A 16-bit configuration word, loaded over a simple register port, sets several things: whether the region is enabled, where it sits, how large it is, how many wait clocks an access takes, and whether those clocks come from an internal counter or from an external acknowledge pin. When a bus cycle hits the enabled region, the block drives an active-low chip-select and per-byte-lane write strobes. It then returns an acknowledge once the programmed wait time has passed.

The wait time is twice a 3-bit code plus one optional extra clock, which comes from a separate input. The all-ones code hands acknowledge to the external pin. A flash-timing option makes chip-select lead the write strobes by one clock. Write attempts on a region marked read-only become a one-clock bus-error pulse when the global error enable is high. The configured data-bus width is always presented on an output.

Top module: `cs_wait_ctrl`

## Requirements
- R1: After reset the configuration word reads back as 0x00B0: the region is disabled, the bus width is 16-bit and the wait code is 011.
- R2: Bits 14 to 9 of the configuration word always read as zero, and writes to them are discarded. Writing 0xFFFF reads back as 0x81FF.
- R3: While enable (bit 0) is 0, chip-select never asserts and no acknowledge is given, even for a matching address.
- R4: An access hits when the upper address bits (address bit 17 and above) equal the base input on every bit at or above position 17+size, where size is the field in bits 3 to 1. Size 0 is a 128 KB region, and each step doubles it.
- R5: With wait code c in bits 6 to 4 (c from 0 to 6) and extra-wait input e, a read keeps chip-select low for 2c+e+1 clocks. Acknowledge is high in the last of those clocks.
- R6: With wait code 111, acknowledge is given in the first clock in which the external acknowledge input is high and the write strobes (for a write) are already active.
- R7: With bit 8 set, a write holds both write strobes high during the first chip-select clock and extends the cycle by that one clock. With bit 8 clear, the strobes fall together with chip-select.
- R8: Reads never assert a write strobe. On writes, the upper strobe follows byte enable 1 and the lower strobe follows byte enable 0.
- R9: When read-only (bit 15) is set and the error enable is high, a hitting write gives a one-clock bus-error pulse, with no chip-select and no acknowledge. Without the error enable, or for a read, the access completes normally.
- R10: The bus-width output equals bit 7 of the configuration word (1 means 16-bit, 0 means 8-bit).
- R11: Chip-select and both write strobes are high in the clock after acknowledge.
- R12: If the access strobe drops before acknowledge, chip-select, the strobes and acknowledge go inactive in that same clock, and the next access restarts the full wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_wdata | input | 16 | Configuration write data |
| reg_rdata | output | 16 | Configuration readback |
| base_hi | input | ADDR_W-RGN_LSB | Region base, address bits from RGN_LSB up |
| bus_as | input | 1 | Access strobe, active high |
| bus_write | input | 1 | 1 = write cycle |
| bus_be | input | 2 | Byte enables, bit 1 upper lane |
| bus_addr_hi | input | ADDR_W-RGN_LSB | Bus address bits from RGN_LSB up |
| err_en | input | 1 | Global bus-error enable |
| ws_extra | input | 1 | Extra single wait clock |
| ext_ack | input | 1 | External acknowledge, active high |
| cs_n | output | 1 | Chip-select, active low |
| uwe_n | output | 1 | Upper-lane write strobe, active low |
| lwe_n | output | 1 | Lower-lane write strobe, active low |
| ack | output | 1 | Cycle acknowledge |
| bus_err | output | 1 | Bus-error pulse |
| bus_wide | output | 1 | Configured data-bus width |

## Verification
Two pairs of functions can fall in the same clock. The first is an abort and the clock in which the counter would give acknowledge. The bench drops the access strobe exactly in that clock and expects acknowledge to stay low, chip-select to go high, and the following access to run the full count again. The second is the external acknowledge and the flash lead clock. The bench holds the external acknowledge high from the start of a flash write and expects acknowledge only in the second chip-select clock, once the strobes are low.

// File: rtl/cs_wait_pkg.sv
package cs_wait_pkg;

    localparam int WS_W   = 3;
    localparam int SIZE_W = 3;

    localparam logic [WS_W-1:0] WS_EXT_CODE = '1;

    // longest internal cycle: top code doubled, extra clock, flash lead
    localparam int MAX_CLKS = 2 * ((1 << WS_W) - 2) + 2;
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic              ro;
        logic [5:0]        rsvd;
        logic              flash;
        logic              wide;
        logic [WS_W-1:0]   ws;
        logic [SIZE_W-1:0] size;
        logic              en;
    } cfg_t;

    localparam logic [15:0] CFG_RESET = 16'h00B0;
    localparam logic [15:0] CFG_WMASK = 16'h81FF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_ERR,
        ST_DONE
    } cyc_state_e;

    function automatic cnt_t wait_clocks(logic [WS_W-1:0] code, logic extra);
        return cnt_t'({code, 1'b0}) + cnt_t'(extra);
    endfunction

endpackage

// File: rtl/cs_cfg_store.sv
module cs_cfg_store
    import cs_wait_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [15:0] wdata,
    output logic [15:0] cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (we) begin
            cfg_q <= wdata & CFG_WMASK;
        end
    end

endmodule

// File: rtl/cs_region_match.sv
module cs_region_match #(
    parameter int SPAN_W = 7,
    parameter int SIZE_W = 3
) (
    input  logic [SPAN_W-1:0] addr_hi,
    input  logic [SPAN_W-1:0] base_hi,
    input  logic [SIZE_W-1:0] size,
    output logic              hit
);

    logic [SPAN_W-1:0] diff;

    // bit j takes part in the compare only above the region span
    for (genvar j = 0; j < SPAN_W; j++) begin : g_bit
        logic care;
        assign care    = (32'(j) >= 32'(size));
        assign diff[j] = care & (addr_hi[j] ^ base_hi[j]);
    end

    assign hit = ~|diff;

endmodule

// File: rtl/cs_cycle_seq.sv
module cs_cycle_seq
    import cs_wait_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            ro,
    input  logic            flash,
    input  logic [WS_W-1:0] ws,
    input  logic            hit,
    input  logic            bus_as,
    input  logic            bus_write,
    input  logic [1:0]      bus_be,
    input  logic            err_en,
    input  logic            ws_extra,
    input  logic            ext_ack,
    output logic            cs_n,
    output logic            uwe_n,
    output logic            lwe_n,
    output logic            ack,
    output logic            bus_err
);

    cyc_state_e state;
    cnt_t       cnt;

    logic start;
    logic deny;
    logic live;
    logic ext_mode;
    logic strobe_on;
    logic done;
    cnt_t lead;
    cnt_t target;

    assign start     = bus_as && en && hit;
    assign deny      = bus_write && ro && err_en;
    assign ext_mode  = (ws == WS_EXT_CODE);
    assign lead      = cnt_t'(flash && bus_write);
    assign target    = wait_clocks(ws, ws_extra) + lead;
    assign strobe_on = (cnt >= lead);
    assign done      = ext_mode ? (ext_ack && strobe_on) : (cnt == target);
    assign live      = (state == ST_ACTIVE) && bus_as;

    assign ack     = live && done;
    assign cs_n    = !live;
    assign uwe_n   = !(live && bus_write && strobe_on && bus_be[1]);
    assign lwe_n   = !(live && bus_write && strobe_on && bus_be[0]);
    assign bus_err = (state == ST_ERR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        state <= deny ? ST_ERR : ST_ACTIVE;
                    end
                end
                ST_ACTIVE: begin
                    if (!bus_as) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else if (done) begin
                        state <= ST_DONE;
                    end else if (cnt != '1) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ERR: begin
                    state <= ST_DONE;
                end
                default: begin
                    if (!bus_as) begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/cs_wait_ctrl.sv
module cs_wait_ctrl
    import cs_wait_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int RGN_LSB = 17
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_we,
    input  logic [15:0]               reg_wdata,
    output logic [15:0]               reg_rdata,
    input  logic [ADDR_W-RGN_LSB-1:0] base_hi,
    input  logic                      bus_as,
    input  logic                      bus_write,
    input  logic [1:0]                bus_be,
    input  logic [ADDR_W-RGN_LSB-1:0] bus_addr_hi,
    input  logic                      err_en,
    input  logic                      ws_extra,
    input  logic                      ext_ack,
    output logic                      cs_n,
    output logic                      uwe_n,
    output logic                      lwe_n,
    output logic                      ack,
    output logic                      bus_err,
    output logic                      bus_wide
);

    localparam int SPAN_W = ADDR_W - RGN_LSB;

    logic [15:0] cfg_bits;
    cfg_t        cfg;
    logic        hit;

    cs_cfg_store u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .wdata (reg_wdata),
        .cfg_q (cfg_bits)
    );

    assign cfg       = cfg_t'(cfg_bits);
    assign reg_rdata = cfg_bits;
    assign bus_wide  = cfg.wide;

    cs_region_match #(
        .SPAN_W (SPAN_W),
        .SIZE_W (SIZE_W)
    ) u_match (
        .addr_hi (bus_addr_hi),
        .base_hi (base_hi),
        .size    (cfg.size),
        .hit     (hit)
    );

    cs_cycle_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg.en),
        .ro        (cfg.ro),
        .flash     (cfg.flash),
        .ws        (cfg.ws),
        .hit       (hit),
        .bus_as    (bus_as),
        .bus_write (bus_write),
        .bus_be    (bus_be),
        .err_en    (err_en),
        .ws_extra  (ws_extra),
        .ext_ack   (ext_ack),
        .cs_n      (cs_n),
        .uwe_n     (uwe_n),
        .lwe_n     (lwe_n),
        .ack       (ack),
        .bus_err   (bus_err)
    );

endmodule

// File: rtl/cs_wait_ctrl_chk.sv
module cs_wait_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] reg_rdata,
    input logic        bus_as,
    input logic        bus_write,
    input logic        cs_n,
    input logic        uwe_n,
    input logic        lwe_n,
    input logic        ack,
    input logic        bus_err
);

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[14:9] == 6'd0);

    p_cs_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> reg_rdata[0]);

    p_flash_lead_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n) && bus_write && reg_rdata[8]) |-> (uwe_n && lwe_n));

    p_we_only_write_r8: assert property (@(posedge clk) disable iff (rst)
        (!uwe_n || !lwe_n) |-> (!cs_n && bus_write));

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> !bus_err);

    p_err_no_cs_r9: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (cs_n && !ack));

    p_release_after_ack_r11: assert property (@(posedge clk) disable iff (rst)
        ack |=> (cs_n && uwe_n && lwe_n));

    p_abort_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !bus_as |-> (cs_n && uwe_n && lwe_n && !ack));

endmodule

bind cs_wait_ctrl cs_wait_ctrl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_rdata (reg_rdata),
    .bus_as    (bus_as),
    .bus_write (bus_write),
    .cs_n      (cs_n),
    .uwe_n     (uwe_n),
    .lwe_n     (lwe_n),
    .ack       (ack),
    .bus_err   (bus_err)
);

// File: tb/cs_wait_ctrl_tb_top.sv
`timescale 1ns/1ps
module cs_wait_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [6:0]  base_hi = 7'h10;
    logic        bus_as = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_be = 2'b11;
    logic [6:0]  bus_addr_hi = 7'h10;
    logic        err_en = 1'b0;
    logic        ws_extra = 1'b0;
    logic        ext_ack = 1'b0;
    logic        cs_n, uwe_n, lwe_n, ack, bus_err, bus_wide;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    int m_cs, m_u, m_l, m_err;
    bit m_ack, m_first_we;

    always #4 clk = ~clk;

    cs_wait_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .base_hi(base_hi), .bus_as(bus_as),
        .bus_write(bus_write), .bus_be(bus_be), .bus_addr_hi(bus_addr_hi),
        .err_en(err_en), .ws_extra(ws_extra), .ext_ack(ext_ack),
        .cs_n(cs_n), .uwe_n(uwe_n), .lwe_n(lwe_n), .ack(ack),
        .bus_err(bus_err), .bus_wide(bus_wide)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_cfg(bit ro, bit fl, bit wide, int code, int size);
        return {ro, 6'd0, fl, wide, 3'(code), 3'(size), 1'b1};
    endfunction

    task automatic wr_cfg(input logic [15:0] v);
        @(negedge clk); reg_we = 1'b1; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic do_access(input logic [6:0] a, input bit wr, input logic [1:0] be,
                             input int ext_at, input int abort_at);
        m_cs = 0; m_u = 0; m_l = 0; m_err = 0; m_ack = 0; m_first_we = 0;
        @(negedge clk);
        bus_addr_hi = a; bus_write = wr; bus_be = be; bus_as = 1'b1;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (i == ext_at) ext_ack = 1'b1;
            if (i == abort_at) begin
                bus_as = 1'b0;
                #1;
                chk(cs_n && uwe_n && lwe_n && !ack, "R12 abort quiet", {cs_n, uwe_n, lwe_n, ack}, 4'b1110);
                break;
            end
            #1;
            if (!cs_n) m_cs++;
            if (!uwe_n) m_u++;
            if (!lwe_n) m_l++;
            if (bus_err) m_err++;
            if (i == 0) m_first_we = !uwe_n || !lwe_n;
            if (ack) begin
                m_ack = 1;
                break;
            end
        end
        if (m_ack) begin
            @(negedge clk); #1;
            chk(cs_n && uwe_n && lwe_n, "R11 release after ack", {cs_n, uwe_n, lwe_n}, 3'b111);
        end
        @(negedge clk);
        bus_as = 1'b0; ext_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk(reg_rdata == 16'h00B0, "R1 reset value", reg_rdata, 16'h00B0);
        chk(bus_wide == 1'b1, "R10 reset width", bus_wide, 1);
        do_access(7'h10, 0, 2'b11, -1, -1);
        chk(m_cs == 0 && !m_ack, "R3 disabled no cs", m_cs, 0);
    endtask

    task automatic t_reserved();
        wr_cfg(16'hFFFF); #1;
        chk(reg_rdata == 16'h81FF, "R2 reserved bits", reg_rdata, 16'h81FF);
        wr_cfg(mk_cfg(0, 0, 1, 2, 0) & 16'hFFFE); #1;
        do_access(7'h10, 1, 2'b11, -1, -1);
        chk(m_cs == 0 && !m_ack, "R3 enable clear", m_cs, 0);
    endtask

    task automatic t_wait();
        int codes[3] = '{0, 3, 6};
        foreach (codes[k]) begin
            for (int e = 0; e < 2; e++) begin
                wr_cfg(mk_cfg(0, 0, 1, codes[k], 0));
                ws_extra = e[0];
                do_access(7'h10, 0, 2'b11, -1, -1);
                chk(m_ack && m_cs == 2 * codes[k] + e + 1, "R5 wait count", m_cs, 2 * codes[k] + e + 1);
                chk(m_u == 0 && m_l == 0, "R8 read no strobes", m_u + m_l, 0);
            end
        end
        ws_extra = 1'b0;
    endtask

    task automatic t_flash();
        wr_cfg(mk_cfg(0, 1, 1, 1, 0));
        do_access(7'h10, 1, 2'b11, -1, -1);
        chk(m_cs == 4 && m_u == 3 && m_l == 3, "R7 flash write length", m_cs, 4);
        chk(!m_first_we, "R7 flash lead clock", m_first_we, 0);
        do_access(7'h10, 0, 2'b11, -1, -1);
        chk(m_cs == 3 && m_u == 0 && m_l == 0, "R8 flash read", m_cs, 3);
        wr_cfg(mk_cfg(0, 0, 1, 1, 0));
        do_access(7'h10, 1, 2'b11, -1, -1);
        chk(m_cs == 3 && m_u == 3 && m_first_we, "R7 no lead", m_cs, 3);
        do_access(7'h10, 1, 2'b10, -1, -1);
        chk(m_u == 3 && m_l == 0, "R8 upper lane only", m_l, 0);
        do_access(7'h10, 1, 2'b01, -1, -1);
        chk(m_u == 0 && m_l == 3, "R8 lower lane only", m_u, 0);
    endtask

    task automatic t_ext();
        wr_cfg(mk_cfg(0, 0, 1, 7, 0));
        do_access(7'h10, 0, 2'b11, 5, -1);
        chk(m_ack && m_cs == 6, "R6 external ack", m_cs, 6);
        wr_cfg(mk_cfg(0, 1, 1, 7, 0));
        do_access(7'h10, 1, 2'b11, 0, -1);
        chk(m_ack && m_cs == 2 && m_u == 1, "R6 ext ack waits for lead", m_cs, 2);
    endtask

    task automatic t_decode();
        wr_cfg(mk_cfg(0, 0, 1, 0, 0));
        do_access(7'h10, 0, 2'b11, -1, -1);
        chk(m_ack && m_cs == 1, "R4 size0 hit", m_cs, 1);
        do_access(7'h11, 0, 2'b11, -1, -1);
        chk(!m_ack && m_cs == 0, "R4 size0 miss", m_cs, 0);
        wr_cfg(mk_cfg(0, 0, 1, 0, 1));
        do_access(7'h11, 0, 2'b11, -1, -1);
        chk(m_ack && m_cs == 1, "R4 size1 hit", m_cs, 1);
        do_access(7'h12, 0, 2'b11, -1, -1);
        chk(!m_ack && m_cs == 0, "R4 size1 miss", m_cs, 0);
    endtask

    task automatic t_err();
        wr_cfg(mk_cfg(1, 0, 1, 1, 0));
        err_en = 1'b1;
        do_access(7'h10, 1, 2'b11, -1, -1);
        chk(m_err == 1 && m_cs == 0 && !m_ack, "R9 protected write", m_err, 1);
        do_access(7'h10, 0, 2'b11, -1, -1);
        chk(m_err == 0 && m_ack && m_cs == 3, "R9 protected read", m_cs, 3);
        err_en = 1'b0;
        do_access(7'h10, 1, 2'b11, -1, -1);
        chk(m_err == 0 && m_ack && m_cs == 3, "R9 error disabled", m_cs, 3);
    endtask

    task automatic t_width();
        wr_cfg(mk_cfg(0, 0, 0, 0, 0)); #1;
        chk(bus_wide == 1'b0, "R10 narrow width", bus_wide, 0);
        wr_cfg(mk_cfg(0, 0, 1, 0, 0)); #1;
        chk(bus_wide == 1'b1, "R10 wide width", bus_wide, 1);
    endtask

    task automatic t_abort();
        wr_cfg(mk_cfg(0, 0, 1, 1, 0));
        do_access(7'h10, 0, 2'b11, -1, 2);
        do_access(7'h10, 0, 2'b11, -1, -1);
        chk(m_ack && m_cs == 3, "R12 full count after abort", m_cs, 3);
        wr_cfg(mk_cfg(0, 0, 1, 3, 0));
        do_access(7'h10, 1, 2'b11, -1, 3);
        do_access(7'h10, 1, 2'b11, -1, -1);
        chk(m_ack && m_cs == 7 && m_u == 7, "R12 restart write", m_cs, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reserved();
        t_wait();
        t_flash();
        t_ext();
        t_decode();
        t_err();
        t_width();
        t_abort();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule